// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel NOR flash. Once a program or erase command has been sent to the device by other logic, a one-cycle start pulse hands this controller the kind of operation (program, erase, or wait for an erase suspend to take hold) and the byte that should end up in the array. The controller then asks a bus-read port for status bytes, one after another, until it can tell that the device has finished, failed or suspended. It reports the result as a one-cycle done or fail pulse. After a failure it holds a request for a Read/Reset command until the surrounding logic confirms that the command was sent.

A parameter picks how completion is judged. The polling method watches the top status bit. The toggle method waits for bit 6 to stop changing between reads. In both methods the byte read after settling is verified for program and erase. A raised error bit triggers a short recheck before failure is declared. A programmable read limit stops the controller from waiting forever on a hung device.

The state machine has three states. Idle waits for a start. Read requests status bytes and judges each one. Reset-wait holds the Read/Reset request. The transitions are: accept (Idle to Read on a valid start), finish (Read to Idle when a byte settles and verifies), reject (Read to Reset-wait on a failed verify, an exhausted recheck or a read-limit timeout), and release (Reset-wait to Idle on the reset acknowledgement).

Top module: `nor_poll_ctrl`

## Requirements
- R1: In Idle, a start with mode code 0 (program), 1 (erase) or 2 (suspend-wait) moves the block to Read, so that busy and rd_req are high in the next cycle. A start with code 3 is ignored.
- R2: rd_req stays high until rd_ack is seen. Each cycle with rd_req and rd_ack both high consumes one status byte on rd_data, and the next read is requested at once if no outcome was reached.
- R3: With the polling method (USE_TOGGLE=0), a byte settles in these cases. For program, bit 7 equals bit 7 of the expected byte. For erase, bit 7 is 1. For suspend-wait, bit 7 is 1 and was 0 in the previous read of the same operation.
- R4: With the toggle method (USE_TOGGLE=1), a byte settles when its bit 6 equals bit 6 of the previous read of the same operation, in every mode. The first read of an operation never settles.
- R5: When a byte settles, the operation is done if the whole byte equals the expected byte (program), equals 8'hFF (erase), or in any case (suspend-wait). Otherwise it fails.
- R6: When an unsettled byte has bit 5 set and no recheck is running, exactly two more reads follow. If neither settles, fail is reported after the second one.
- R7: If the read count reaches max_reads without settling, fail is reported together with fail_timeout. A max_reads of 0 acts as 1. An exhausted recheck reports fail without fail_timeout, and it takes precedence over the timeout.
- R8: done and fail are single-cycle pulses in the cycle after the deciding read. They are never high together, and fail_timeout is only high together with fail.
- R9: After a fail, rst_req stays high and starts are ignored until rst_done is seen, and then the block returns to Idle. A done returns the block to Idle directly, with no reset request.
- R10: A start that arrives while polling is in progress is ignored. The outcome follows the mode and byte that were originally accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| start_mode | input | 2 | 0 program, 1 erase, 2 suspend-wait, 3 invalid |
| start_data | input | 8 | Expected byte (used for program) |
| max_reads | input | CNT_W | Read limit before timeout |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Status byte returned by the device |
| busy | output | 1 | High outside Idle |
| done | output | 1 | Success pulse |
| fail | output | 1 | Failure pulse |
| fail_timeout | output | 1 | Failure was caused by the read limit |
| rst_req | output | 1 | Request to issue a Read/Reset command |
| rst_done | input | 1 | Read/Reset command has been issued |

## Verification
Some properties are checked by assertions on every cycle. A read request is held until it is acknowledged. A failure always comes with a Read/Reset request, and that request is held until it is acknowledged. Read and reset requests are never high together. The result pulses last one cycle, never overlap, and carry a timeout flag only with a failure. Other behaviour needs the bench's scenarios, which compare both method variants against an independent model of the status bits: which read decides the outcome, verify mismatches after settling, the two-read recheck after an error bit, the timeout with its precedence, and starts that are ignored during polling or while the reset is pending.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_SUSP  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_READ    = 2'd1,
        S_RSTWAIT = 2'd2
    } state_e;

    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;
    localparam int ERR_BIT    = 5;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam int RECHECK_READS = 2;

endpackage

// File: rtl/nor_poll_judge.sv
module nor_poll_judge
    import nor_poll_pkg::*;
#(
    parameter bit USE_TOGGLE = 1'b0
) (
    input  op_e        op,
    input  logic [7:0] exp_byte,
    input  logic [7:0] prev_byte,
    input  logic       have_prev,
    input  logic [7:0] cur_byte,
    output logic       settled,
    output logic       verify_ok
);

    generate
        if (USE_TOGGLE) begin : g_toggle
            always_comb begin
                settled = have_prev &&
                          (cur_byte[TOGGLE_BIT] == prev_byte[TOGGLE_BIT]);
            end
        end else begin : g_poll
            always_comb begin
                unique case (op)
                    OP_PROG:  settled = (cur_byte[POLL_BIT] == exp_byte[POLL_BIT]);
                    OP_ERASE: settled = cur_byte[POLL_BIT];
                    default:  settled = have_prev && !prev_byte[POLL_BIT]
                                        && cur_byte[POLL_BIT];
                endcase
            end
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_PROG:  verify_ok = (cur_byte == exp_byte);
            OP_ERASE: verify_ok = (cur_byte == ERASED_BYTE);
            default:  verify_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/nor_poll_count.sv
module nor_poll_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last_read
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_next;

    assign cnt_next  = {1'b0, cnt_q} + 1'b1;
    assign last_read = (cnt_next >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_next[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/nor_poll_ctrl.sv
module nor_poll_ctrl
    import nor_poll_pkg::*;
#(
    parameter bit USE_TOGGLE = 1'b0,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       start_mode,
    input  logic [7:0]       start_data,
    input  logic [CNT_W-1:0] max_reads,
    output logic             rd_req,
    input  logic             rd_ack,
    input  logic [7:0]       rd_data,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             fail_timeout,
    output logic             rst_req,
    input  logic             rst_done
);

    localparam int LEFT_W = $clog2(RECHECK_READS + 1);
    localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(RECHECK_READS);

    state_e            state_q, state_d;
    op_e               op_q;
    logic [7:0]        exp_q, prev_q;
    logic              have_prev_q, rech_q;
    logic [LEFT_W-1:0] left_q;

    logic accept, rd_fire, settled, verify_ok, last_read;
    logic finish_ok, finish_bad, rech_exhaust, time_out, enter_rech, any_fail;

    assign accept  = (state_q == S_IDLE) && start && (start_mode != OP_NONE);
    assign rd_fire = (state_q == S_READ) && rd_ack;

    nor_poll_judge #(.USE_TOGGLE(USE_TOGGLE)) u_judge (
        .op        (op_q),
        .exp_byte  (exp_q),
        .prev_byte (prev_q),
        .have_prev (have_prev_q),
        .cur_byte  (rd_data),
        .settled   (settled),
        .verify_ok (verify_ok)
    );

    nor_poll_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (rd_fire),
        .limit     (max_reads),
        .last_read (last_read)
    );

    assign finish_ok    = rd_fire && settled && verify_ok;
    assign finish_bad   = rd_fire && settled && !verify_ok;
    assign rech_exhaust = rd_fire && !settled && rech_q && (left_q == LEFT_W'(1));
    assign time_out     = rd_fire && !settled && !rech_exhaust && last_read;
    assign enter_rech   = rd_fire && !settled && !rech_q && !last_read
                          && rd_data[ERR_BIT];
    assign any_fail     = finish_bad || rech_exhaust || time_out;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept)    state_d = S_READ;
            S_READ:    if (finish_ok) state_d = S_IDLE;
                       else if (any_fail) state_d = S_RSTWAIT;
            S_RSTWAIT: if (rst_done)  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            op_q        <= OP_PROG;
            exp_q       <= '0;
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            rech_q      <= 1'b0;
            left_q      <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q        <= op_e'(start_mode);
                exp_q       <= start_data;
                have_prev_q <= 1'b0;
                rech_q      <= 1'b0;
                left_q      <= '0;
            end else if (rd_fire) begin
                prev_q      <= rd_data;
                have_prev_q <= 1'b1;
                if (enter_rech) begin
                    rech_q <= 1'b1;
                    left_q <= LEFT_INIT;
                end else if (rech_q && !settled) begin
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done         <= 1'b0;
            fail         <= 1'b0;
            fail_timeout <= 1'b0;
        end else begin
            done         <= finish_ok;
            fail         <= any_fail;
            fail_timeout <= time_out;
        end
    end

    assign rd_req  = (state_q == S_READ);
    assign rst_req = (state_q == S_RSTWAIT);
    assign busy    = (state_q != S_IDLE);

endmodule

// File: rtl/nor_poll_chk.sv
module nor_poll_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic rd_ack,
    input logic done,
    input logic fail,
    input logic fail_timeout,
    input logic rst_req,
    input logic rst_done
);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req);

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    fail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    // R7
    timeout_with_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_timeout |-> fail);

    // R9
    fail_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> rst_req);

    // R9
    reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req && !rst_done |=> rst_req);

    // R9
    no_read_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !rd_req);

endmodule

bind nor_poll_ctrl nor_poll_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .rd_ack       (rd_ack),
    .done         (done),
    .fail         (fail),
    .fail_timeout (fail_timeout),
    .rst_req      (rst_req),
    .rst_done     (rst_done)
);

// File: tb/sim_nor_poll_ctrl.sv
`timescale 1ns/1ps
module sim_nor_poll_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] start_mode = 2'd0;
    logic [7:0] start_data = 8'd0;
    logic [7:0] max_reads = 8'd4;
    logic       rd_ack = 1'b0;
    logic [7:0] rd_data = 8'd0;
    logic       rst_done = 1'b0;

    logic rd_req0, busy0, done0, fail0, to0, rrq0;
    logic rd_req1, busy1, done1, fail1, to1, rrq1;

    always #2.5 clk = ~clk;

    nor_poll_ctrl #(.USE_TOGGLE(1'b0), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
        .start_data(start_data), .max_reads(max_reads), .rd_req(rd_req0),
        .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy0), .done(done0),
        .fail(fail0), .fail_timeout(to0), .rst_req(rrq0), .rst_done(rst_done)
    );

    nor_poll_ctrl #(.USE_TOGGLE(1'b1), .CNT_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
        .start_data(start_data), .max_reads(max_reads), .rd_req(rd_req1),
        .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy1), .done(done1),
        .fail(fail1), .fail_timeout(to1), .rst_req(rrq1), .rst_done(rst_done)
    );

    logic [7:0] seq [16];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // outcome model: kind 0 done, 1 fail, 2 timeout fail; end = deciding read
    function automatic logic [9:0] model(input bit tog, input logic [1:0] mode,
                                         input logic [7:0] d, input int maxr);
        logic [7:0] prev, cur;
        bit hp, rech, st, vok;
        int left, lim;
        hp = 0; rech = 0; left = 0; prev = 8'd0;
        lim = (maxr < 1) ? 1 : maxr;
        for (int i = 0; i < 16; i++) begin
            cur = seq[i];
            if (tog) st = hp && (cur[6] == prev[6]);            // R4
            else begin                                          // R3
                case (mode)
                    2'd0:    st = (cur[7] == d[7]);
                    2'd1:    st = cur[7];
                    default: st = hp && !prev[7] && cur[7];
                endcase
            end
            vok = (mode == 2'd0) ? (cur == d) :
                  (mode == 2'd1) ? (cur == 8'hFF) : 1'b1;       // R5
            if (st) return {(vok ? 2'd0 : 2'd1), 8'(i + 1)};
            if (rech && left == 1) return {2'd1, 8'(i + 1)};   // R6
            if (i + 1 >= lim) return {2'd2, 8'(i + 1)};        // R7
            if (rech) left--;
            else if (cur[5]) begin rech = 1; left = 2; end
            prev = cur; hp = 1;
        end
        return {2'd2, 8'd16};
    endfunction

    task automatic run_op(input logic [1:0] mode, input logic [7:0] d,
                          input int maxr, input bit poke);
        logic [9:0] m0, m1;
        int e0, e1, k0, k1, lim;
        m0 = model(1'b0, mode, d, maxr);
        m1 = model(1'b1, mode, d, maxr);
        e0 = int'(m0[7:0]); k0 = int'(m0[9:8]);
        e1 = int'(m1[7:0]); k1 = int'(m1[9:8]);
        lim = (e0 > e1) ? e0 : e1;
        start = 1'b1; start_mode = mode; start_data = d; max_reads = 8'(maxr);
        @(negedge clk);
        start = 1'b0;
        chk(busy0 && rd_req0, "R1", "u0 busy/rd_req after start", int'(rd_req0), 1);
        chk(busy1 && rd_req1, "R1", "u1 busy/rd_req after start", int'(rd_req1), 1);
        for (int i = 0; i < lim; i++) begin
            rd_ack = 1'b1;
            rd_data = seq[i];
            if (poke && i == 0) begin   // R10: start during polling
                start = 1'b1; start_mode = 2'd1 - (mode & 2'd1); start_data = ~d;
            end
            @(negedge clk);
            start = 1'b0; start_mode = mode; start_data = d;
            chk(done0 == (i + 1 == e0 && k0 == 0), "R8", "u0 done pulse", int'(done0), int'(i + 1 == e0 && k0 == 0));
            chk(fail0 == (i + 1 == e0 && k0 != 0), "R5", "u0 fail pulse", int'(fail0), int'(i + 1 == e0 && k0 != 0));
            chk(to0 == (i + 1 == e0 && k0 == 2), "R7", "u0 timeout", int'(to0), int'(i + 1 == e0 && k0 == 2));
            chk(done1 == (i + 1 == e1 && k1 == 0), "R4", "u1 done pulse", int'(done1), int'(i + 1 == e1 && k1 == 0));
            chk(fail1 == (i + 1 == e1 && k1 != 0), "R6", "u1 fail pulse", int'(fail1), int'(i + 1 == e1 && k1 != 0));
            chk(to1 == (i + 1 == e1 && k1 == 2), "R7", "u1 timeout", int'(to1), int'(i + 1 == e1 && k1 == 2));
            if (i + 1 < e0) chk(rd_req0, "R2", "u0 keeps requesting", int'(rd_req0), 1);
            if (i + 1 < e1) chk(rd_req1, "R2", "u1 keeps requesting", int'(rd_req1), 1);
        end
        rd_ack = 1'b0;
        chk(!rd_req0 && !rd_req1, "R2", "requests stop after outcome", int'(rd_req0 | rd_req1), 0);
        chk(rrq0 == (k0 != 0), "R9", "u0 rst_req after outcome", int'(rrq0), int'(k0 != 0));
        chk(rrq1 == (k1 != 0), "R9", "u1 rst_req after outcome", int'(rrq1), int'(k1 != 0));
        if (k0 != 0 && k1 != 0) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            chk(rrq0 && rrq1 && !rd_req0 && !rd_req1, "R9", "start ignored in reset wait",
                int'(rd_req0 | rd_req1), 0);
        end
        rst_done = 1'b1;
        @(negedge clk);
        rst_done = 1'b0;
        chk(!busy0 && !busy1 && !rrq0 && !rrq1, "R9", "idle after rst_done",
            int'(busy0 | busy1), 0);
    endtask

    task automatic fill(input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [7:0] e,
                        input logic [7:0] f);
        seq[0] = a; seq[1] = b; seq[2] = c; seq[3] = e; seq[4] = f;
        for (int i = 5; i < 16; i++) seq[i] = f;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy0 && !rd_req0 && !rrq0 && !done0 && !fail0, "R8", "u0 reset state", int'(busy0), 0);
        chk(!busy1 && !rd_req1 && !rrq1 && !done1 && !fail1, "R8", "u1 reset state", int'(busy1), 0);

        // R1: mode code 3 ignored
        start = 1'b1; start_mode = 2'd3;
        @(negedge clk);
        start = 1'b0;
        chk(!busy0 && !busy1, "R1", "code 3 start ignored", int'(busy0 | busy1), 0);

        // R3 R4: program, toggling then settled
        fill(8'h40, 8'h00, 8'h40, 8'hA5, 8'hA5); run_op(2'd0, 8'hA5, 8, 1'b0);
        // R5 R6: program 0->1 attempt, error bit, wrong data
        fill(8'h60, 8'h20, 8'h7E, 8'h7E, 8'h7E); run_op(2'd0, 8'hFF, 8, 1'b0);
        // R3: erase success
        fill(8'h08, 8'h48, 8'h08, 8'hFF, 8'hFF); run_op(2'd1, 8'h00, 8, 1'b0);
        // R3: suspend bit7 rises
        fill(8'h40, 8'h00, 8'h80, 8'h80, 8'h80); run_op(2'd2, 8'h00, 8, 1'b0);
        // R7: toggling forever
        for (int i = 0; i < 16; i++) seq[i] = (i % 2 == 0) ? 8'h40 : 8'h00;
        run_op(2'd1, 8'h00, 6, 1'b0);
        // R7: limit of zero acts as one
        run_op(2'd0, 8'h80, 0, 1'b0);
        // R5: erase settles with non-erased byte
        fill(8'h40, 8'h00, 8'hFE, 8'hFE, 8'hFE); run_op(2'd1, 8'h00, 8, 1'b0);
        // R6: recheck recovers
        fill(8'h60, 8'h20, 8'h81, 8'h81, 8'h81); run_op(2'd0, 8'h81, 8, 1'b0);
        // R10: start during polling
        fill(8'h40, 8'h00, 8'h40, 8'h3C, 8'h3C); run_op(2'd0, 8'h3C, 8, 1'b1);

        // random mix
        for (int t = 0; t < 60; t++) begin
            logic [1:0] md;
            logic [7:0] dd;
            int mr;
            md = 2'($urandom % 3);
            dd = 8'($urandom);
            mr = 1 + int'($urandom % 16);
            for (int i = 0; i < 16; i++) begin
                case ($urandom % 4)
                    0: seq[i] = dd;
                    1: seq[i] = 8'hFF;
                    default: seq[i] = 8'($urandom);
                endcase
            end
            run_op(md, dd, mr, 1'(($urandom % 2)));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule